// File: doc/BRIEF.md
# ADC Conversion and Power Sequencer

This block sits on the host side of a multiplexed successive-approximation converter with a serial port. A single request carries an 8-bit configuration word that names the input pairing (single-ended against the common pin, or one of four adjacent differential pairs in either polarity), the span (5 V or 10 V, unipolar or bipolar) and the power mode wanted after the next conversion. The block raises the convert-start line, waits for the converter's busy line to return high, and then runs a 16-clock serial frame. The frame sends the new configuration word on the data-in line and gathers the previous conversion result from the data-out line. When the frame ends, a one-cycle done pulse presents the result together with the word that was sent in that frame.

The block also keeps track of the converter's power state from the events it produces itself. Nap starts at the busy rise that ends the conversion after a nap request and ends at the second falling SCK of the next frame. Sleep starts at the last falling SCK of a frame that asks for it. A request that arrives while the converter sleeps first runs the wake sequence: a convert-start rising edge, a frame with the sleep bit forced to zero, and then a settle wait counted in system clocks. Only after that wait does the requested conversion run.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Each frame sends the 8-bit word MSB first in its first 8 SCK periods, followed by 8 low bits. Word fields: bit 7 single-ended, bit 6 odd/sign, bits 5:4 pair select, bit 3 unipolar, bit 2 10 V span, bit 1 nap, bit 0 sleep.
- R2: SCK is low when no frame runs. Each high phase and each low phase lasts `sck_half` clocks (0 is treated as 1). SDI changes only while SCK is low.
- R3: The 16 SDO bits are sampled on the SCK rising edges, MSB first. After the 16th falling edge a one-cycle `done` presents the result and the word sent in that frame.
- R4: A conversion holds `adc_convst` high for CONV_HI_CYCLES clocks and then low. SCK does not rise while `adc_busy` is low, and the frame starts only after the busy rise.
- R5: After a frame whose word has nap=1 and sleep=0, `pwr_state` reads 1 (nap) from the busy rise of the next conversion until the 2nd falling SCK of the following frame, and then 0 (on). A word with nap=0 causes no nap.
- R6: A frame with sleep=1 sets `pwr_state` to 2 (sleep) at its 16th falling SCK, whatever the nap bit is.
- R7: While `pwr_state` is 2, `adc_convst` never falls. Its only change is the single rising edge that starts the wake sequence.
- R8: A request accepted during sleep gives one convert-start rising edge, then a frame carrying the word with bit 0 cleared. `pwr_state` then reads 3 (settling) for exactly SETTLE_CYCLES clocks with `adc_convst` low, and after that the requested conversion runs.
- R9: `req_ready` is high only when the block is idle. A `req_valid` given while `req_ready` is low is ignored.
- R10: After reset `req_ready`=1, `adc_convst`=0, `adc_sck`=0, `done`=0 and `pwr_state`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_word | input | 8 | Configuration word for the request |
| req_ready | output | 1 | Block idle and able to accept a request |
| sck_half | input | DIV_W | SCK half-period in clocks |
| adc_convst | output | 1 | Convert-start line to the converter |
| adc_busy | input | 1 | Converter busy line, low while converting |
| adc_sck | output | 1 | Serial clock |
| adc_sdi | output | 1 | Serial data to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| done | output | 1 | One-cycle result strobe |
| done_result | output | 16 | Result captured in the finished frame |
| done_word | output | 8 | Word sent in the finished frame |
| pwr_state | output | 2 | 0 on, 1 nap, 2 sleep, 3 settling |

## Verification
Several functions land on the same clock edge. The busy rise that ends a conversion also starts the frame and, when a nap is armed, moves the power state to nap. The bench requests a nap and then a second conversion, and reads the power state one cycle after the busy rise. In a wake frame the 16th falling SCK ends the frame, drops convert-start and enters the settle count all at once. The bench counts the settling cycles, checks that convert-start stays low during them, and checks that convert-start never falls while the converter sleeps.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and field positions for the ADC conversion and power sequencer.
package adc_seq_pkg;
    localparam int CFG_W     = 8;   // configuration word width
    localparam int FRAME_LEN = 16;  // SCK periods per frame
    localparam int BIT_NAP   = 1;   // nap request bit in the word
    localparam int BIT_SLEEP = 0;   // sleep request bit in the word

    typedef enum logic [1:0] {
        PWR_ON    = 2'd0,
        PWR_NAP   = 2'd1,
        PWR_SLEEP = 2'd2,
        PWR_WAKE  = 2'd3
    } pwr_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CONV_HI, SQ_CONV_WAIT, SQ_FRAME,
        SQ_WAKE_HI, SQ_WAKE_FRAME, SQ_SETTLE
    } seq_e;
endpackage

// File: rtl/adc_frame_shifter.sv
`timescale 1ns/1ps
// Serial frame engine. On start it runs FRAME_LEN SCK periods of
// 2*half_div clocks each. SCK idles low, SDI shifts on falling edges and
// SDO is sampled on rising edges. Assumes half_div is held stable during a
// frame and that start is only given while the engine is idle.
module adc_frame_shifter
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 8,
    localparam int IDX_W = $clog2(FRAME_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CFG_W-1:0]     word_in,
    input  logic [DIV_W-1:0]     half_div,
    input  logic                 sdo,
    output logic                 sck,
    output logic                 sdi,
    output logic                 active,
    output logic                 fall_now,
    output logic [IDX_W-1:0]     fall_idx,
    output logic                 last_now,
    output logic [FRAME_LEN-1:0] rx_word,
    output logic [CFG_W-1:0]     word_q
);
    logic [DIV_W-1:0]     half_cnt;
    logic [DIV_W-1:0]     half_lim;
    logic [IDX_W-1:0]     falls_q;
    logic [FRAME_LEN-1:0] tx_sr;
    logic [FRAME_LEN-1:0] rx_sr;
    logic                 sck_q;
    logic                 edge_now;

    // A zero divider behaves as one.
    assign half_lim = (half_div == '0) ? DIV_W'(1) : half_div;
    // An SCK edge is due when the half-period count expires.
    assign edge_now = active && (half_cnt == half_lim - DIV_W'(1));
    assign fall_now = edge_now && sck_q;
    assign fall_idx = falls_q + IDX_W'(1);
    assign last_now = fall_now && (falls_q == IDX_W'(FRAME_LEN - 1));
    assign sck      = sck_q;
    assign sdi      = tx_sr[FRAME_LEN-1];
    assign rx_word  = rx_sr;

    // Frame sequencing: load, toggle SCK, shift out on fall, sample on rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            sck_q    <= 1'b0;
            half_cnt <= '0;
            falls_q  <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            word_q   <= '0;
        end else if (start && !active) begin
            active   <= 1'b1;
            sck_q    <= 1'b0;
            half_cnt <= '0;
            falls_q  <= '0;
            tx_sr    <= {word_in, {(FRAME_LEN - CFG_W){1'b0}}};
            rx_sr    <= '0;
            word_q   <= word_in;
        end else if (active) begin
            if (edge_now) begin
                half_cnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_sr <= {rx_sr[FRAME_LEN-2:0], sdo};
                end else begin
                    sck_q   <= 1'b0;
                    tx_sr   <= {tx_sr[FRAME_LEN-2:0], 1'b0};
                    falls_q <= falls_q + IDX_W'(1);
                    if (last_now) active <= 1'b0;
                end
            end else begin
                half_cnt <= half_cnt + DIV_W'(1);
            end
        end
    end

    // R2: data out is held for the whole high phase of SCK.
    a_r2_sdi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(sdi));
    // R1: a frame ends only after its full count of falling edges.
    a_r1_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(falls_q) == IDX_W'(FRAME_LEN - 1)));
endmodule

// File: rtl/adc_pwr_tracker.sv
`timescale 1ns/1ps
// Converter power-state tracker. Follows on, nap, sleep and settling from
// the busy rise and the SCK falling-edge events of the frame engine, and
// counts the wake settle time in system clocks. Assumes the frame events
// are single-cycle strobes aligned with the SCK falling edge.
module adc_pwr_tracker
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1000,
    localparam int IDX_W = $clog2(FRAME_LEN + 1),
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_rise,
    input  logic             fall_now,
    input  logic [IDX_W-1:0] fall_idx,
    input  logic             last_now,
    input  logic             frm_nap,
    input  logic             frm_sleep,
    output pwr_e             pwr
);
    logic             nap_armed;
    logic [CNT_W-1:0] settle_cnt;

    // Power-state transitions and the nap arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr        <= PWR_ON;
            nap_armed  <= 1'b0;
            settle_cnt <= '0;
        end else begin
            if (last_now) nap_armed <= frm_nap && !frm_sleep;
            unique case (pwr)
                PWR_ON: begin
                    if (last_now && frm_sleep) begin
                        pwr <= PWR_SLEEP;
                    end else if (busy_rise && nap_armed) begin
                        pwr       <= PWR_NAP;
                        nap_armed <= 1'b0;
                    end
                end
                PWR_NAP: begin
                    if (fall_now && fall_idx == IDX_W'(2)) pwr <= PWR_ON;
                end
                PWR_SLEEP: begin
                    if (last_now && !frm_sleep) begin
                        pwr        <= PWR_WAKE;
                        settle_cnt <= '0;
                    end
                end
                PWR_WAKE: begin
                    if (settle_cnt == CNT_W'(SETTLE_CYCLES - 1)) pwr <= PWR_ON;
                    else settle_cnt <= settle_cnt + CNT_W'(1);
                end
                default: pwr <= PWR_ON;
            endcase
        end
    end

    // R5: nap ends at the second falling SCK of the frame.
    a_r5_nap_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_NAP && fall_now && fall_idx == IDX_W'(2)) |=> (pwr == PWR_ON));
    // R6: a sleep word always ends in sleep, nap bit or not.
    a_r6_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (last_now && frm_sleep) |=> (pwr == PWR_SLEEP));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// Top of the ADC conversion and power sequencer. Accepts a request,
// pulses convert-start, waits for the busy rise, runs one serial frame and
// reports the result. While the converter sleeps, the wake sequence and
// settle wait run first. Assumes adc_busy and adc_sdo are synchronous to clk.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DIV_W          = 8,
    parameter int CONV_HI_CYCLES = 4,
    parameter int SETTLE_CYCLES  = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CFG_W-1:0]     req_word,
    output logic                 req_ready,
    input  logic [DIV_W-1:0]     sck_half,
    output logic                 adc_convst,
    input  logic                 adc_busy,
    output logic                 adc_sck,
    output logic                 adc_sdi,
    input  logic                 adc_sdo,
    output logic                 done,
    output logic [FRAME_LEN-1:0] done_result,
    output logic [CFG_W-1:0]     done_word,
    output logic [1:0]           pwr_state
);
    localparam int HI_W  = $clog2(CONV_HI_CYCLES + 1);
    localparam int IDX_W = $clog2(FRAME_LEN + 1);

    seq_e                 state;
    logic [HI_W-1:0]      hi_cnt;
    logic [CFG_W-1:0]     cur_word;
    logic                 busy_q;
    logic                 busy_rise;
    logic                 frm_start;
    logic [CFG_W-1:0]     frm_word;
    logic                 frm_active;
    logic                 fall_now;
    logic [IDX_W-1:0]     fall_idx;
    logic                 last_now;
    logic [FRAME_LEN-1:0] rx_word;
    logic [CFG_W-1:0]     frm_word_q;
    pwr_e                 pwr;

    assign busy_rise  = adc_busy && !busy_q;
    assign frm_start  = (state == SQ_CONV_WAIT && busy_rise) || (state == SQ_WAKE_HI);
    assign frm_word   = (state == SQ_WAKE_HI) ? (cur_word & ~(CFG_W'(1) << BIT_SLEEP)) : cur_word;
    assign adc_convst = (state == SQ_CONV_HI) || (state == SQ_WAKE_HI) || (state == SQ_WAKE_FRAME);
    assign req_ready  = (state == SQ_IDLE);
    assign pwr_state  = pwr;

    // Busy edge detector; the line idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b1;
        else        busy_q <= adc_busy;
    end

    // Request sequencer: conversion, frame, wake and settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            hi_cnt      <= '0;
            cur_word    <= '0;
            done        <= 1'b0;
            done_result <= '0;
            done_word   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    hi_cnt <= '0;
                    if (req_valid) begin
                        cur_word <= req_word;
                        state    <= (pwr == PWR_SLEEP) ? SQ_WAKE_HI : SQ_CONV_HI;
                    end
                end
                SQ_CONV_HI: begin
                    if (hi_cnt == HI_W'(CONV_HI_CYCLES - 1)) state <= SQ_CONV_WAIT;
                    else hi_cnt <= hi_cnt + HI_W'(1);
                end
                SQ_CONV_WAIT: if (busy_rise) state <= SQ_FRAME;
                SQ_FRAME: begin
                    if (last_now) begin
                        done        <= 1'b1;
                        done_result <= rx_word;
                        done_word   <= cur_word;
                        state       <= SQ_IDLE;
                    end
                end
                SQ_WAKE_HI:    state <= SQ_WAKE_FRAME;
                SQ_WAKE_FRAME: if (last_now) state <= SQ_SETTLE;
                SQ_SETTLE: begin
                    if (pwr == PWR_ON) begin
                        hi_cnt <= '0;
                        state  <= SQ_CONV_HI;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    adc_frame_shifter #(.DIV_W(DIV_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (frm_start),
        .word_in  (frm_word),
        .half_div (sck_half),
        .sdo      (adc_sdo),
        .sck      (adc_sck),
        .sdi      (adc_sdi),
        .active   (frm_active),
        .fall_now (fall_now),
        .fall_idx (fall_idx),
        .last_now (last_now),
        .rx_word  (rx_word),
        .word_q   (frm_word_q)
    );

    adc_pwr_tracker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_rise (busy_rise),
        .fall_now  (fall_now),
        .fall_idx  (fall_idx),
        .last_now  (last_now),
        .frm_nap   (frm_word_q[BIT_NAP]),
        .frm_sleep (frm_word_q[BIT_SLEEP]),
        .pwr       (pwr)
    );

    // R4: a conversion frame is entered only on a busy rise.
    a_r4_frame_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_FRAME && $past(state) == SQ_CONV_WAIT) |-> $past(busy_rise));
    // R4: SCK stays low while the converter reports busy.
    a_r4_no_sck_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_busy |-> !adc_sck);
    // R7: convert-start never falls during sleep.
    a_r7_sleep_convst: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_SLEEP && $past(pwr) == PWR_SLEEP) |-> !$fell(adc_convst));
    // R8: no convert-start while the reference settles.
    a_r8_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_WAKE) |-> !adc_convst);
    // R3: the done strobe lasts a single cycle.
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: a frame never runs while a request could be accepted.
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !frm_active);
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: a converter model answers the frames, the driver task
// queues the expected results and frame words, and the monitors compare them.
module adc_seq_ctrl_test;
    localparam int CONV_HI = 3;
    localparam int SETTLE  = 37;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_word = '0;
    logic [7:0]  sck_half = 8'd2;
    logic        req_ready, adc_convst, adc_sck, adc_sdi, done;
    logic        adc_busy;
    logic        adc_sdo;
    logic [15:0] done_result;
    logic [7:0]  done_word;
    logic [1:0]  pwr_state;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.DIV_W(8), .CONV_HI_CYCLES(CONV_HI), .SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_ready(req_ready), .sck_half(sck_half), .adc_convst(adc_convst),
        .adc_busy(adc_busy), .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
        .done(done), .done_result(done_result), .done_word(done_word),
        .pwr_state(pwr_state)
    );

    int n_chk = 0, n_fail = 0, cycles = 0;
    logic [23:0] exp_q[$];
    logic [7:0]  sdi_q[$];
    logic [7:0]  last_cfg = '0;
    logic [7:0]  conv_n = '0;
    bit          asleep_exp = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Converter model: busy after convert-start, result shifted out, word taken in.
    logic        sck_q, cv_q, m_asleep, m_frame_ev;
    logic [7:0]  m_cfg, m_conv;
    logic [15:0] m_sr, m_rx, m_frame_word;
    int          m_rises, btimer;
    assign adc_sdo = m_sr[15];
    always @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 0; cv_q <= 0; m_asleep <= 0; m_frame_ev <= 0; adc_busy <= 1;
            m_cfg <= 0; m_conv <= 0; m_sr <= 0; m_rx <= 0; m_rises <= 0; btimer <= 0;
            m_frame_word <= 0;
        end else begin
            sck_q <= adc_sck;
            cv_q <= adc_convst;
            m_frame_ev <= 1'b0;
            if (adc_convst && !cv_q && !m_asleep) begin
                adc_busy <= 1'b0;
                btimer <= 20;
            end else if (!adc_busy) begin
                if (btimer == 0) begin
                    adc_busy <= 1'b1;
                    m_sr <= {m_cfg ^ 8'h5A, m_conv};
                    m_conv <= m_conv + 8'd1;
                end else btimer <= btimer - 1;
            end
            if (adc_sck && !sck_q) begin
                m_rx <= {m_rx[14:0], adc_sdi};
                m_sr <= {m_sr[14:0], 1'b0};
                m_rises <= m_rises + 1;
            end
            if (!adc_sck && sck_q && m_rises == 16) begin
                m_cfg <= m_rx[15:8];
                m_asleep <= m_rx[8];
                m_rises <= 0;
                m_frame_ev <= 1'b1;
                m_frame_word <= m_rx;
            end
        end
    end

    // Monitors, sampled on the falling clock edge.
    logic prev_sck = 0, prev_sdi = 0, prev_cv = 0;
    logic [1:0] prev_pwr = 0, cv_start_pwr = 0;
    int hi_run = 0, cv_run = 0;
    int half_bad = 0, sdi_bad = 0, busy_sck_bad = 0, cv_width_bad = 0;
    int wake_cnt = 0, wake_cv = 0, sleep_falls = 0, sleep_rises = 0, dones = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                dones++;
                if (exp_q.size() == 0) chk(0, "R3 unexpected done", {done_result, done_word}, 0);
                else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk({done_result, done_word} == e, "R3 result/word", {done_result, done_word}, e);
                end
            end
            if (m_frame_ev) begin
                if (sdi_q.size() == 0) chk(0, "R1 unexpected frame", m_frame_word, 0);
                else begin
                    logic [7:0] w;
                    w = sdi_q.pop_front();
                    chk(m_frame_word == {w, 8'h00}, "R1 frame word", m_frame_word, {w, 8'h00});
                end
            end
            if (adc_sck) hi_run++;
            if (!adc_sck && prev_sck) begin
                if (hi_run != ((sck_half == 0) ? 1 : int'(sck_half))) half_bad++;
                hi_run = 0;
            end
            if (adc_sck && prev_sck && adc_sdi != prev_sdi) sdi_bad++;
            if (adc_sck && !adc_busy) busy_sck_bad++;
            if (adc_convst && !prev_cv) begin
                cv_run = 0;
                cv_start_pwr = pwr_state;
                if (pwr_state == 2'd2) sleep_rises++;
            end
            if (adc_convst) cv_run++;
            if (!adc_convst && prev_cv) begin
                if (cv_start_pwr != 2'd2 && cv_run != CONV_HI) cv_width_bad++;
                if (pwr_state == 2'd2 && prev_pwr == 2'd2) sleep_falls++;
            end
            if (pwr_state == 2'd3) begin
                wake_cnt++;
                if (adc_convst) wake_cv++;
                if (req_ready) wake_cv++;
            end
            prev_sck = adc_sck; prev_sdi = adc_sdi; prev_cv = adc_convst; prev_pwr = pwr_state;
        end
    end

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            summary_and_end();
        end
    end

    // Driver: one request, with expected frame words and result queued.
    task automatic send(input logic [7:0] w);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_word  = w;
        @(negedge clk);
        req_valid = 1'b0;
        if (asleep_exp) begin
            sdi_q.push_back(w & 8'hFE);
            last_cfg = w & 8'hFE;
        end
        exp_q.push_back({last_cfg ^ 8'h5A, conv_n, w});
        sdi_q.push_back(w);
        conv_n = conv_n + 8'd1;
        last_cfg = w;
        asleep_exp = w[0];
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset values
        chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
        chk(adc_convst == 1'b0, "R10 convst", adc_convst, 0);
        chk(adc_sck == 1'b0, "R10 sck", adc_sck, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(pwr_state == 2'd0, "R10 power", pwr_state, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3: plain conversions, single-ended and differential words
        send(8'hC8);
        send(8'h34);
        wait_idle();

        // R9: requests during a conversion are ignored
        send(8'h5C);
        chk(req_ready == 1'b0, "R9 ready low when busy", req_ready, 0);
        req_valid = 1'b1; req_word = 8'hFF;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk(pwr_state == 2'd0, "R9 ignored word took no effect", pwr_state, 0);
        chk(dones == 3, "R9 no extra result", dones, 3);

        // R5: nap armed by a word, entered at the next busy rise
        send(8'h92);
        wait_idle();
        chk(pwr_state == 2'd0, "R5 on before next conversion", pwr_state, 0);
        send(8'h90);
        @(posedge adc_busy);
        @(posedge clk);
        @(negedge clk);
        chk(pwr_state == 2'd1, "R5 nap after busy rise", pwr_state, 1);
        wait_idle();
        chk(pwr_state == 2'd0, "R5 on after second SCK", pwr_state, 0);
        send(8'h90);
        @(posedge adc_busy);
        @(posedge clk);
        @(negedge clk);
        chk(pwr_state == 2'd0, "R5 no nap without request", pwr_state, 0);
        wait_idle();

        // R6: sleep with nap also set
        send(8'h83);
        wait_idle();
        chk(pwr_state == 2'd2, "R6 sleep entered", pwr_state, 2);

        // R7 R8: wake sequence and settle window
        wake_cnt = 0; wake_cv = 0; sleep_rises = 0; sleep_falls = 0;
        send(8'hA6);
        wait_idle();
        chk(wake_cnt == SETTLE, "R8 settle length", wake_cnt, SETTLE);
        chk(wake_cv == 0, "R8 quiet during settle", wake_cv, 0);
        chk(sleep_rises == 1, "R7 single wake edge", sleep_rises, 1);
        chk(sleep_falls == 0, "R7 no convst fall in sleep", sleep_falls, 0);

        // R2 R6 R8: faster divider, sleep then wake again
        sck_half = 8'd1;
        send(8'h3B);
        wait_idle();
        chk(pwr_state == 2'd2, "R6 sleep at fast divider", pwr_state, 2);
        wake_cnt = 0;
        send(8'h44);
        wait_idle();
        chk(wake_cnt == SETTLE, "R8 settle length fast", wake_cnt, SETTLE);
        chk(pwr_state == 2'd0, "R8 powered after wake", pwr_state, 0);

        // Closing checks on counters and queues
        chk(half_bad == 0, "R2 SCK phase length", half_bad, 0);
        chk(sdi_bad == 0, "R2 SDI stable while SCK high", sdi_bad, 0);
        chk(busy_sck_bad == 0, "R4 no SCK while busy", busy_sck_bad, 0);
        chk(cv_width_bad == 0, "R4 convert-start width", cv_width_bad, 0);
        chk(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
        chk(sdi_q.size() == 0, "R1 all frames seen", sdi_q.size(), 0);
        summary_and_end();
    end
endmodule